// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Source Selector

This block gathers 64 level-sensitive interrupt inputs and presents them to a single processor on two lines: a normal interrupt line and a fast interrupt line. Each source has its own configuration word. Two routing bits in that word decide whether the source can drive the normal line, the fast line, both, or neither. Software reaches the configuration words and a selector word over a simple valid/ready register bus with 32-bit data.

The selector word lets an interrupt handler find the source to service with a single read. It combines a pending flag with the number of the lowest-numbered source that is asserted and routed to either line. A handler first checks the pending flag, because the number field means nothing while that flag is clear. Inputs are levels, not edges. A source therefore stays visible until its device drops the line or until software clears its routing bits.

Top module: `lvl_intc`

## Requirements
- R1: After reset every configuration word reads zero, `irq_o` and `fiq_o` are low, and the selector reads zero, even while every source input is high.
- R2: The configuration word for source n is at byte address 4*n. Only bit 5 (normal route) and bit 6 (fast route) are stored, and every other bit reads zero.
- R3: `irq_o` is high one clock after any source input is high while that source's bit 5 is set.
- R4: `fiq_o` is high one clock after any source input is high while that source's bit 6 is set.
- R5: Writing zero to a source's routing bits stops that source from driving either line and from appearing in the selector.
- R6: The selector word at byte address 0x104 has bit 6 set when any source is asserted and routed to either line. Bits 5:0 then hold the number of the lowest-numbered such source.
- R7: When no routed source is asserted, the selector reads exactly zero, so both the flag and the number are zero.
- R8: Sources are levels. Once a routed source input drops, its effect on `irq_o`, `fiq_o` and the selector is gone one clock later.
- R9: Reads from any other address return zero. Writes to any other address, including the read-only selector, change nothing.
- R10: `req_ready` is high whenever the block is out of reset. A read accepted on a clock edge produces `rsp_valid` with its data on the next edge. Writes produce no response.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 64 | Level interrupt inputs, one per source |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
On every cycle, the assertions check the response timing of the bus and the quiet state of both lines after reset. They also check that both lines fall one clock after all inputs drop, and that the selector's pending flag agrees with the OR of the two lines. The same checks confirm that a clear flag always comes with a zero number. Only the bench scenarios can show the following: which source the selector picks when several are asserted, the exact stored bits of each configuration word, the separate routing to each line, and the fact that writes to unmapped addresses or to the selector leave the configuration untouched.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BUS_DW = 32;

  typedef struct packed {
    logic fast;
    logic norm;
  } route_t;
endpackage

// File: rtl/intc_cfg_bank.sv
module intc_cfg_bank #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  intc_pkg::route_t  wr_route,
  output logic [N_SRC-1:0]  norm_en,
  output logic [N_SRC-1:0]  fast_en
);
  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        norm_en[n] <= 1'b0;
        fast_en[n] <= 1'b0;
      end else if (wr_en && (wr_word == WORD_W'(n))) begin
        norm_en[n] <= wr_route.norm;
        fast_en[n] <= wr_route.fast;
      end
    end
  end
endmodule

// File: rtl/intc_find_first.sv
module intc_find_first #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_rd_path.sv
module intc_rd_path #(
  parameter int unsigned N_SRC    = 64,
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned SRC_W    = 6,
  parameter int unsigned SEL_WORD = 65,
  parameter int unsigned NORM_BIT = 5,
  parameter int unsigned FAST_BIT = 6,
  parameter int unsigned PEND_BIT = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [WORD_W-1:0]             rd_word,
  input  logic [N_SRC-1:0]              norm_en,
  input  logic [N_SRC-1:0]              fast_en,
  input  logic                          sel_pend,
  input  logic [SRC_W-1:0]              sel_num,
  output logic                          rsp_valid,
  output logic [intc_pkg::BUS_DW-1:0]   rsp_data
);
  localparam int unsigned DW = intc_pkg::BUS_DW;

  logic [DW-1:0] rd_mux;
  logic [SRC_W-1:0] src_idx;

  assign src_idx = rd_word[SRC_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (rd_word < WORD_W'(N_SRC)) begin
      rd_mux[NORM_BIT] = norm_en[src_idx];
      rd_mux[FAST_BIT] = fast_en[src_idx];
    end else if (rd_word == WORD_W'(SEL_WORD)) begin
      rd_mux[PEND_BIT]    = sel_pend;
      rd_mux[SRC_W-1:0]   = sel_num;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_data  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int unsigned N_SRC    = 64,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SEL_ADDR = 'h104,
  parameter int unsigned NORM_BIT = 5,
  parameter int unsigned FAST_BIT = 6,
  parameter int unsigned PEND_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned SRC_W    = $clog2(N_SRC);
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned SEL_WORD = SEL_ADDR >> 2;

  logic [WORD_W-1:0] word;
  logic              wr_en;
  logic              rd_en;
  intc_pkg::route_t  wr_route;
  logic [N_SRC-1:0]  norm_en;
  logic [N_SRC-1:0]  fast_en;
  logic [N_SRC-1:0]  live;
  logic              any_live;
  logic [SRC_W-1:0]  first_live;
  logic              sel_pend_q;
  logic [SRC_W-1:0]  sel_num_q;
  logic              irq_q;
  logic              fiq_q;
  logic              unused_bits;

  assign req_ready = ~rst;
  assign word      = req_addr[ADDR_W-1:2];
  assign wr_en     = req_valid && req_ready && req_write;
  assign rd_en     = req_valid && req_ready && !req_write;
  assign wr_route  = '{fast: req_wdata[FAST_BIT], norm: req_wdata[NORM_BIT]};
  assign unused_bits = ^{req_addr[1:0], req_wdata};

  intc_cfg_bank #(.N_SRC(N_SRC), .WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(word), .wr_route(wr_route),
    .norm_en(norm_en), .fast_en(fast_en)
  );

  assign live = src_i & (norm_en | fast_en);

  intc_find_first #(.N(N_SRC), .IDX_W(SRC_W)) u_pick (
    .req(live), .found(any_live), .idx(first_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      fiq_q      <= 1'b0;
      sel_pend_q <= 1'b0;
      sel_num_q  <= '0;
    end else begin
      irq_q      <= |(src_i & norm_en);
      fiq_q      <= |(src_i & fast_en);
      sel_pend_q <= any_live;
      sel_num_q  <= any_live ? first_live : '0;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  intc_rd_path #(
    .N_SRC(N_SRC), .WORD_W(WORD_W), .SRC_W(SRC_W), .SEL_WORD(SEL_WORD),
    .NORM_BIT(NORM_BIT), .FAST_BIT(FAST_BIT), .PEND_BIT(PEND_BIT)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_word(word),
    .norm_en(norm_en), .fast_en(fast_en),
    .sel_pend(sel_pend_q), .sel_num(sel_num_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned SRC_W = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] src_i,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             sel_pend,
  input logic [SRC_W-1:0] sel_num
);
  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && !rsp_valid && !sel_pend));

  // R10
  a_r10_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
    req_ready);

  // R10
  a_r10_read_answered: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R10
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R8
  a_r8_lines_fall: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |=> (!irq_o && !fiq_o && !sel_pend));

  // R6
  a_r6_flag_matches_lines: assert property (@(posedge clk) disable iff (rst)
    sel_pend == (irq_o || fiq_o));

  // R7
  a_r7_idle_number_zero: assert property (@(posedge clk) disable iff (rst)
    !sel_pend |-> (sel_num == '0));

  // R3
  a_r3_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(src_i) != '0));
endmodule

bind lvl_intc lvl_intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .rsp_valid(rsp_valid),
  .irq_o(irq_o), .fiq_o(fiq_o), .sel_pend(sel_pend_q), .sel_num(sel_num_q)
);

// File: tb/lvl_intc_bench.sv
`timescale 1ns/1ps
module lvl_intc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_o;
  logic        fiq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  lvl_intc u_lvl_intc (
    .clk(clk), .rst(rst), .src_i(src_i), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10 no response to write", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    check("R10 ready", {31'd0, req_ready}, 32'd1);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 response one cycle later", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lines(input string tag, input logic ei, input logic ef);
    check({tag, " irq_o"}, {31'd0, irq_o}, {31'd0, ei});
    check({tag, " fiq_o"}, {31'd0, fiq_o}, {31'd0, ef});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    lines("R1 after reset", 1'b0, 1'b0);
    bus_read(12'h000, 32'h0, "R1 cfg0 reset");
    bus_read(12'h0FC, 32'h0, "R1 cfg63 reset");
    set_src('1);
    lines("R1 masked sources", 1'b0, 1'b0);
    bus_read(12'h104, 32'h0, "R1 selector masked");
    set_src('0);
    // R3 normal route, R6 selector
    bus_write(12'h01C, 32'h20);
    bus_read(12'h01C, 32'h20, "R2 cfg7 readback");
    set_src(64'h80);
    lines("R3 src7 normal", 1'b1, 1'b0);
    bus_read(12'h104, 32'h47, "R6 selector src7");
    // R4 fast route, lowest wins
    bus_write(12'h0A0, 32'h40);
    set_src(64'h80 | (64'h1 << 40));
    lines("R4 src40 fast + src7", 1'b1, 1'b1);
    bus_read(12'h104, 32'h47, "R6 lowest of 7,40");
    set_src(64'h1 << 40);
    lines("R8 src7 dropped", 1'b0, 1'b1);
    bus_read(12'h104, 32'h68, "R8 selector src40");
    // R5 disable
    set_src(64'h80);
    bus_write(12'h01C, 32'h0);
    @(negedge clk);
    lines("R5 src7 disabled", 1'b0, 1'b0);
    bus_read(12'h104, 32'h0, "R5 selector after disable");
    bus_read(12'h01C, 32'h0, "R5 cfg7 cleared");
    // R2 stored bits only, boundary source 63
    bus_write(12'h0FC, 32'hFFFF_FFFF);
    bus_read(12'h0FC, 32'h60, "R2 cfg63 only route bits");
    set_src(64'h1 << 63);
    lines("R3 R4 src63 both", 1'b1, 1'b1);
    bus_read(12'h104, 32'h7F, "R6 selector src63");
    // source 0 boundary and R7 idle selector
    bus_write(12'h000, 32'h20);
    set_src(64'h1 | (64'h1 << 63));
    bus_read(12'h104, 32'h40, "R6 selector src0");
    set_src('0);
    lines("R8 all dropped", 1'b0, 1'b0);
    bus_read(12'h104, 32'h0, "R7 selector idle");
    // R9 unmapped and read-only
    bus_write(12'h100, 32'h0);
    bus_write(12'h104, 32'h7F);
    bus_write(12'h200, 32'h60);
    bus_read(12'h000, 32'h20, "R9 cfg0 untouched");
    bus_read(12'h100, 32'h0, "R9 read 0x100");
    bus_read(12'h200, 32'h0, "R9 read 0x200");
    bus_read(12'h104, 32'h0, "R9 selector write ignored");
    set_src(64'h1 << 50);
    lines("R9 unmapped write routed nothing", 1'b0, 1'b0);
    set_src('0);
    @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule